// File: doc/BRIEF.md
# Unsigned Fixed-Point Reciprocal Estimator

This block turns a 32-bit unsigned operand into a coarse estimate of its reciprocal. The operand is read as a fraction in [0,1). Only the leading nine bits matter: the top bit and the eight bits below it select one of 256 estimates. Each estimate is a nine-bit value, rounded to nearest. Any operand below one half has no representable estimate, so the block saturates it to all ones. The rounding rule is the one used by the floating-point estimate path, so the two paths agree whenever they form the same index.

A result is accepted with `in_valid` and shows up one clock later with `out_valid`. There is no backpressure. The output stage is a two-state machine:
- `OUT_IDLE` means no result is presented.
- `OUT_LIVE` means the registered result is valid.

The transitions are `IDLE->LIVE` on `in_valid`, `LIVE->LIVE` on `in_valid`, `LIVE->IDLE` without `in_valid`, and `IDLE->IDLE` without `in_valid`. The output data register changes only when an operand is accepted.

Top module: `ufix_recip_est`

## Requirements
- R1: An accepted operand with bit 31 clear produces out_data = 0xFFFFFFFF.
- R2: For an accepted operand with bit 31 set, the index is q = 256 + in_data[30:23]. The estimate is s = floor(262144/(2q+1) + 0.5), which always lies in 256..511.
- R3: For an operand with bit 31 set, out_data[31] = 1, out_data[30:23] = s[7:0] and out_data[22:0] = 0.
- R4: in_data[22:0] has no effect on out_data.
- R5: out_valid is high in exactly the cycle after each cycle in which in_valid is high.
- R6: While in_valid is low, out_data keeps its last value whatever in_data carries.
- R7: During reset, out_valid is 0 and out_data is 0.
- R8: At the index extremes, operand 0x80000000 gives 0xFF800000 and operand 0xFF800000 gives 0x80000000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand qualifier |
| in_data | input | 32 | Unsigned fraction operand |
| out_valid | output | 1 | Result valid, one cycle after acceptance |
| out_data | output | 32 | Reciprocal estimate or saturation value |

## Verification
The hardest thing to show from the ports is that the 23 low operand bits are truly ignored. A fault that leaks one of them would still pass a sweep that leaves those bits at zero. The stimulus therefore holds each chosen index fixed and randomises everything below it across consecutive accepted operands. It also changes in_data freely during idle cycles to expose any load without in_valid. A full sweep of all 256 indices is compared against a floating-point evaluation of the rounding formula, and random operands below one half exercise saturation.

// File: rtl/ufix_recip_pkg.sv
`timescale 1ns/1ps
package ufix_recip_pkg;
    // Output slot of the registered stage
    typedef enum logic [0:0] {
        OUT_IDLE = 1'b0,
        OUT_LIVE = 1'b1
    } out_state_e;

    // Operand classification
    typedef enum logic [0:0] {
        KIND_SAT = 1'b0,
        KIND_EST = 1'b1
    } op_kind_e;
endpackage

// File: rtl/recip_index_split.sv
`timescale 1ns/1ps
module recip_index_split
    import ufix_recip_pkg::*;
#(
    parameter int unsigned IDX_W = 8
) (
    input  logic [IDX_W:0] lead_bits,   // operand msb followed by IDX_W index bits
    output op_kind_e       kind,
    output logic [IDX_W:0] q_index
);
    always_comb begin
        kind    = lead_bits[IDX_W] ? KIND_EST : KIND_SAT;
        // q = 2^IDX_W + index field
        q_index = {1'b1, lead_bits[IDX_W-1:0]};
    end
endmodule

// File: rtl/recip_round_div.sv
`timescale 1ns/1ps
module recip_round_div #(
    parameter int unsigned IDX_W = 8
) (
    input  logic [IDX_W:0] q_index,
    output logic [IDX_W:0] est
);
    // round(2^(2*IDX_W+2) / (2q+1)) == (2^(2*IDX_W+3) + (2q+1)) / (2*(2q+1))
    localparam int unsigned ODD_W = IDX_W + 2;
    localparam int unsigned NUM_W = 2 * IDX_W + 4;
    localparam int unsigned DEN_W = IDX_W + 3;
    localparam int unsigned QUO_W = IDX_W + 1;
    localparam int unsigned GAP_W = NUM_W - 1 - ODD_W;

    logic [ODD_W-1:0] odd;
    logic [NUM_W-1:0] num;
    logic [DEN_W-1:0] den;

    assign odd = {q_index, 1'b1};
    assign num = {1'b1, {GAP_W{1'b0}}, odd};
    assign den = {odd, 1'b0};

    // Partial remainders; the initial one is below den for every legal q,
    // so the quotient fits in QUO_W bits.
    logic [DEN_W-1:0] part [QUO_W:1];
    assign part[QUO_W] = num[NUM_W-1:QUO_W];

    for (genvar i = QUO_W - 1; i >= 0; i--) begin : g_step
        logic [DEN_W:0] trial;
        logic [DEN_W:0] diff;
        logic           ge;
        assign trial  = {part[i+1], num[i]};
        assign diff   = trial - {1'b0, den};
        assign ge     = (trial >= {1'b0, den});
        assign est[i] = ge;
        if (i > 0) begin : g_rem
            assign part[i] = ge ? diff[DEN_W-1:0] : trial[DEN_W-1:0];
        end
    end
endmodule

// File: rtl/recip_out_stage.sv
`timescale 1ns/1ps
module recip_out_stage
    import ufix_recip_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned IDX_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  op_kind_e          kind,
    input  logic [IDX_W:0]    est,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);
    localparam int unsigned PAD_W = DATA_W - IDX_W - 1;

    out_state_e state, state_nxt;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= OUT_IDLE;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            OUT_IDLE: state_nxt = in_valid ? OUT_LIVE : OUT_IDLE;
            OUT_LIVE: state_nxt = in_valid ? OUT_LIVE : OUT_IDLE;
            default:  state_nxt = OUT_IDLE;
        endcase
    end

    assign out_valid = (state == OUT_LIVE);

    // Output data register: loads only on acceptance.
    // est[IDX_W] is always 1 for a legal index and lands in the msb.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_data <= '0;
        end else if (in_valid) begin
            unique case (kind)
                KIND_SAT: out_data <= '1;
                KIND_EST: out_data <= {est, {PAD_W{1'b0}}};
                default:  out_data <= '1;
            endcase
        end
    end
endmodule

// File: rtl/ufix_recip_est.sv
`timescale 1ns/1ps
module ufix_recip_est
    import ufix_recip_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned IDX_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);
    localparam int unsigned LEAD_W = IDX_W + 1;
    localparam int unsigned PAD_W  = DATA_W - LEAD_W;

    op_kind_e          kind;
    logic [IDX_W:0]    q_index;
    logic [IDX_W:0]    est;
    logic              low_bits_unused;

    // Bits below the index never reach the estimate
    assign low_bits_unused = ^in_data[PAD_W-1:0];

    recip_index_split #(.IDX_W(IDX_W)) u_split (
        .lead_bits (in_data[DATA_W-1 -: LEAD_W]),
        .kind      (kind),
        .q_index   (q_index)
    );

    recip_round_div #(.IDX_W(IDX_W)) u_div (
        .q_index (q_index),
        .est     (est)
    );

    recip_out_stage #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .kind      (kind),
        .est       (est),
        .out_valid (out_valid),
        .out_data  (out_data)
    );
endmodule

// File: rtl/ufix_recip_est_chk.sv
`timescale 1ns/1ps
module ufix_recip_est_chk #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned IDX_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [DATA_W-1:0] in_data,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_data
);
    localparam int unsigned PAD_W = DATA_W - IDX_W - 1;

    // R5: valid follows acceptance by one cycle
    a_r5_valid_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r5_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R1: operands below one half saturate
    a_r1_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_data[DATA_W-1]) |=> (out_data == {DATA_W{1'b1}}));

    // R3: estimate format has msb set and zero padding
    a_r3_format: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_data[DATA_W-1]) |=>
            (out_data[DATA_W-1] && (out_data[PAD_W-1:0] == '0)));

    // R6: no load while idle
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_data));

    // R8: lowest index gives the largest estimate
    a_r8_low_end: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_data[DATA_W-1 -: IDX_W+1] == {1'b1, {IDX_W{1'b0}}}) |=>
            (out_data == {1'b1, {IDX_W{1'b1}}, {PAD_W{1'b0}}}));
endmodule

bind ufix_recip_est ufix_recip_est_chk #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/ufix_recip_est_bench.sv
`timescale 1ns/1ps
module ufix_recip_est_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_data = '0;
    logic        out_valid;
    logic [31:0] out_data;

    int checks = 0;
    int failures = 0;
    logic        exp_valid = 1'b0;
    logic [31:0] exp_data = '0;

    always #2 clk = ~clk;

    ufix_recip_est u_ufix_recip_est (
        .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .in_data (in_data),
        .out_valid (out_valid), .out_data (out_data)
    );

    // Behavioural reference of the requirements (R1, R2, R3)
    function automatic logic [31:0] ref_model(input logic [31:0] op);
        int q;
        int s;
        real r;
        if (!op[31]) return 32'hFFFF_FFFF;
        q = 256 + int'(op[30:23]);
        r = 262144.0 / real'(2 * q + 1);
        s = $rtoi($floor(r + 0.5));
        return {1'b1, 8'(s % 256), 23'd0};
    endfunction

    task automatic check(input string tag);
        checks++;
        if (out_valid !== exp_valid || out_data !== exp_data) begin
            failures++;
            $display("FAIL %s: valid=%0b data=%08h expected valid=%0b data=%08h",
                     tag, out_valid, out_data, exp_valid, exp_data);
        end
    endtask

    // Called at a falling edge: drive, let the rising edge pass, check.
    task automatic cycle(input logic v, input logic [31:0] d, input string tag);
        in_valid = v;
        in_data  = d;
        @(posedge clk);
        exp_valid = v;
        if (v) exp_data = ref_model(d);
        @(negedge clk);
        check(tag);
    endtask

    task automatic fixed(input logic [31:0] d, input logic [31:0] want, input string tag);
        in_valid = 1'b1;
        in_data  = d;
        @(posedge clk);
        exp_valid = 1'b1;
        exp_data  = want;
        @(negedge clk);
        check(tag);
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R7 reset state");
        rst_n = 1'b1;
        @(negedge clk);
        check("R7 after release");

        // R2 R3: every index, low bits zero
        for (int i = 0; i < 256; i++)
            cycle(1'b1, {1'b1, 8'(i), 23'd0}, "R2 R3 index sweep");

        // R8: the two ends of the index range, constant expectations
        fixed(32'h8000_0000, 32'hFF80_0000, "R8 lowest index");
        fixed(32'hFF80_0000, 32'h8000_0000, "R8 highest index");
        fixed(32'hFFFF_FFFF, 32'h8000_0000, "R8 highest index all ones");

        // R1: saturation, edges and random
        fixed(32'h0000_0000, 32'hFFFF_FFFF, "R1 zero");
        fixed(32'h7FFF_FFFF, 32'hFFFF_FFFF, "R1 just below half");
        for (int i = 0; i < 200; i++)
            cycle(1'b1, $urandom & 32'h7FFF_FFFF, "R1 random below half");

        // R4: fixed index, random low bits
        for (int k = 0; k < 16; k++) begin
            logic [7:0] idx = 8'($urandom);
            for (int j = 0; j < 8; j++)
                cycle(1'b1, {1'b1, idx, 23'($urandom)}, "R4 low bits ignored");
        end

        // R5 R6: idle cycles with moving data, then back-to-back and gaps
        cycle(1'b1, 32'hC000_0000, "R5 load before idle");
        for (int i = 0; i < 20; i++)
            cycle(1'b0, $urandom, "R6 hold while idle");
        for (int i = 0; i < 100; i++)
            cycle(1'($urandom), $urandom, "R5 R6 mixed valid");

        // R7: reset in the middle of traffic
        cycle(1'b1, 32'hA5A5_A5A5, "R5 before second reset");
        rst_n = 1'b0;
        exp_valid = 1'b0;
        exp_data  = '0;
        @(negedge clk);
        check("R7 mid-run reset");
        rst_n = 1'b1;
        cycle(1'b1, 32'hF0F0_F0F0, "R2 after reset");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule